// File: doc/BRIEF.md
# Ping-Pong Receive DMA Buffer Controller

This block drains a receive byte FIFO into system memory through a simple write-request port, one byte per accepted request. Software sets a maximum buffer length and up to two 24-bit buffer base addresses. The byte address starts at the active base for each new buffer and steps by one per byte. When a buffer fills up before the packet ends, the block raises a buffer-full flag. When the last byte of a packet lands in the current buffer, it raises an end-of-packet flag and latches the packet's byte count for software.

After an end of packet the block stops accepting bytes until software writes the release command. In alternating mode the block swaps between the two base addresses by itself each time a buffer completes, by either flag. In single mode it always returns to the first base address. After a buffer-full in single mode it also clears its own receive enable, so software must re-arm it before more data moves.

Top module: `rx_pingpong_dma`

## Requirements
- R1: A memory write request (`mem_req`) is raised only while the DMA enable (CTRL bit 0, register 0) and the receive enable (CTRL bit 1) are both set and no release is pending. The FIFO byte moves on a cycle where `mem_req` and `mem_ack` are both high.
- R2: The first byte of each buffer is written at the active base address. Each following byte in that buffer is written at the previous address plus one.
- R3: When a byte brings the current buffer to MAXSZ bytes and is not the packet's last byte, flag bit 0 of ISR (register 12) is set and the next byte begins a new buffer. MAXSZ is written at register 8 (low byte) and register 9 (high byte).
- R4: When a byte carries `fifo_last`, flag bit 1 of ISR is set. If the same byte also fills the buffer, only bit 1 is set.
- R5: At end of packet, the number of bytes in the whole packet, counted across buffer boundaries, is latched and read at register 10 (low byte) and register 11 (high byte).
- R6: After an end of packet no further byte is accepted until bit 0 is written as 1 to the command register (register 1).
- R7: With alternating mode on (CTRL bit 2), every buffer completion swaps the active base between BASE0 (registers 2/3/4, low/mid/high) and BASE1 (registers 5/6/7).
- R8: With alternating mode off, the buffer after any completion starts at BASE0. A buffer-full also clears CTRL bit 1.
- R9: ISR flags are sticky and clear on a read of ISR. `irq` is high while any flag is set whose bit in IMR (register 13, reset value 3, 1 = enabled) is set.
- R10: Base address, MAXSZ and control registers read back the values written. CTRL, ISR and the count read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears ISR on register 12) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| fifo_valid | input | 1 | Receive FIFO has a byte |
| fifo_data | input | 8 | Receive FIFO byte |
| fifo_last | input | 1 | Byte is the last of its packet |
| fifo_ready | output | 1 | FIFO byte taken this cycle when valid |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 24 | Memory byte address |
| mem_data | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory accepts the request |
| irq | output | 1 | Interrupt, level |

## Verification
The bench sends a byte before both enables are set and checks that the byte stays in the FIFO. It then drives packets that cross a buffer boundary, to catch a byte count that restarts per buffer and an address that fails to reload at the base. It sends a packet whose last byte exactly fills the buffer; a design that tests the full condition before the end condition would raise both flags there. It also checks that single mode drops the receive enable after a fill, and that a byte sent before the release command is refused. A design that got either wrong would overwrite the buffer software is still reading.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

  // register offsets
  localparam int RA_CTRL  = 0;
  localparam int RA_CMD   = 1;
  localparam int RA_BASE0 = 2;
  localparam int RA_BASE1 = 5;
  localparam int RA_MAX   = 8;
  localparam int RA_CNT   = 10;
  localparam int RA_ISR   = 12;
  localparam int RA_IMR   = 13;

  // interrupt flag positions
  localparam int FL_FULL = 0;
  localparam int FL_EOP  = 1;
  localparam int NFLAGS  = 2;

  typedef struct packed {
    logic sw_mode;  // bit 2
    logic rx_en;    // bit 1
    logic dma_en;   // bit 0
  } ctrl_t;

  function automatic logic addr_hit(input logic [3:0] a, input int base, input int idx);
    return a == 4'(base + idx);
  endfunction

endpackage

// File: rtl/rpd_regs.sv
module rpd_regs
  import rpd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              rx_en_clr,
  input  logic [SIZE_W-1:0] pkt_count,
  input  logic [NFLAGS-1:0] flags,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] base0,
  output logic [ADDR_W-1:0] base1,
  output logic [SIZE_W-1:0] maxsz,
  output logic [NFLAGS-1:0] imr,
  output logic              release_cmd,
  output logic              isr_rd
);

  localparam int AB = ADDR_W / 8;
  localparam int SB = SIZE_W / 8;

  assign release_cmd = reg_wr && addr_hit(reg_addr, RA_CMD, 0) && reg_wdata[0];
  assign isr_rd      = reg_rd && addr_hit(reg_addr, RA_ISR, 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      base0 <= '0;
      base1 <= '0;
      maxsz <= '0;
      imr   <= '1;
    end else begin
      if (reg_wr) begin
        if (addr_hit(reg_addr, RA_CTRL, 0)) ctrl <= ctrl_t'(reg_wdata[2:0]);
        if (addr_hit(reg_addr, RA_IMR, 0))  imr  <= reg_wdata[NFLAGS-1:0];
        for (int i = 0; i < AB; i++) begin
          if (addr_hit(reg_addr, RA_BASE0, i)) base0[8*i +: 8] <= reg_wdata;
          if (addr_hit(reg_addr, RA_BASE1, i)) base1[8*i +: 8] <= reg_wdata;
        end
        for (int i = 0; i < SB; i++) begin
          if (addr_hit(reg_addr, RA_MAX, i)) maxsz[8*i +: 8] <= reg_wdata;
        end
      end
      // engine clear applied after any software write of the same cycle
      if (rx_en_clr) ctrl.rx_en <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (addr_hit(reg_addr, RA_CTRL, 0)) reg_rdata = {5'b0, ctrl};
    if (addr_hit(reg_addr, RA_ISR, 0))  reg_rdata = 8'(flags);
    if (addr_hit(reg_addr, RA_IMR, 0))  reg_rdata = 8'(imr);
    for (int i = 0; i < AB; i++) begin
      if (addr_hit(reg_addr, RA_BASE0, i)) reg_rdata = base0[8*i +: 8];
      if (addr_hit(reg_addr, RA_BASE1, i)) reg_rdata = base1[8*i +: 8];
    end
    for (int i = 0; i < SB; i++) begin
      if (addr_hit(reg_addr, RA_MAX, i)) reg_rdata = maxsz[8*i +: 8];
      if (addr_hit(reg_addr, RA_CNT, i)) reg_rdata = pkt_count[8*i +: 8];
    end
  end

endmodule

// File: rtl/rpd_engine.sv
module rpd_engine
  import rpd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] base1,
  input  logic [SIZE_W-1:0] maxsz,
  input  logic              release_cmd,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_last,
  output logic              fifo_ready,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              ev_write,
  output logic              ev_full,
  output logic              ev_eop,
  output logic              rx_en_clr,
  output logic              wait_rel,
  output logic [SIZE_W-1:0] pkt_count
);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [SIZE_W-1:0] step_cnt(input logic [SIZE_W-1:0] c);
    return c + 1'b1;
  endfunction

  logic              sel;       // 0: BASE0 active, 1: BASE1 active
  logic              fresh;     // next byte opens a new buffer
  logic [ADDR_W-1:0] cur_addr;
  logic [SIZE_W-1:0] buf_cnt;
  logic [SIZE_W-1:0] run_cnt;

  logic              go;
  logic [ADDR_W-1:0] act_base;
  logic [SIZE_W-1:0] buf_next;
  logic              buf_hit;
  logic              done;

  assign go         = ctrl.dma_en && ctrl.rx_en && !wait_rel;
  assign mem_req    = go && fifo_valid;
  assign fifo_ready = go && mem_ack;
  assign ev_write   = mem_req && mem_ack;
  assign mem_data   = fifo_data;

  assign act_base = sel ? base1 : base0;
  assign mem_addr = fresh ? act_base : cur_addr;
  assign buf_next = step_cnt(fresh ? '0 : buf_cnt);
  assign buf_hit  = buf_next == maxsz;

  // end of packet takes priority over a buffer fill on the same byte
  assign ev_eop    = ev_write && fifo_last;
  assign ev_full   = ev_write && buf_hit && !fifo_last;
  assign done      = ev_eop || ev_full;
  assign rx_en_clr = ev_full && !ctrl.sw_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel       <= 1'b0;
      fresh     <= 1'b1;
      cur_addr  <= '0;
      buf_cnt   <= '0;
      run_cnt   <= '0;
      wait_rel  <= 1'b0;
      pkt_count <= '0;
    end else begin
      if (release_cmd) wait_rel <= 1'b0;
      if (ev_write) begin
        cur_addr <= step_addr(mem_addr);
        buf_cnt  <= buf_next;
        fresh    <= done;
        run_cnt  <= ev_eop ? '0 : step_cnt(run_cnt);
        if (done) sel <= ctrl.sw_mode ? !sel : 1'b0;
        if (ev_eop) begin
          pkt_count <= step_cnt(run_cnt);
          wait_rel  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rpd_irq.sv
module rpd_irq
  import rpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_full,
  input  logic              ev_eop,
  input  logic              isr_rd,
  input  logic [NFLAGS-1:0] imr,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);

  logic [NFLAGS-1:0] set_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[FL_FULL] = ev_full;
    set_vec[FL_EOP]  = ev_eop;
  end

  // a new event in the read cycle survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (isr_rd ? '0 : flags) | set_vec;
  end

  assign irq = |(flags & imr);

endmodule

// File: rtl/rx_pingpong_dma.sv
module rx_pingpong_dma
  import rpd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_last,
  output logic              fifo_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack,
  output logic              irq
);

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] base0, base1;
  logic [SIZE_W-1:0] maxsz, pkt_count;
  logic [NFLAGS-1:0] imr, flags;
  logic              release_cmd, isr_rd, rx_en_clr, wait_rel;
  logic              ev_write, ev_full, ev_eop;

  rpd_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .rx_en_clr, .pkt_count, .flags, .ctrl, .base0, .base1, .maxsz, .imr,
    .release_cmd, .isr_rd
  );

  rpd_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_eng (
    .clk, .rst_n, .ctrl, .base0, .base1, .maxsz, .release_cmd,
    .fifo_valid, .fifo_data, .fifo_last, .fifo_ready, .mem_ack,
    .mem_req, .mem_addr, .mem_data, .ev_write, .ev_full, .ev_eop,
    .rx_en_clr, .wait_rel, .pkt_count
  );

  rpd_irq u_irq (
    .clk, .rst_n, .ev_full, .ev_eop, .isr_rd, .imr, .flags, .irq
  );

endmodule

// File: rtl/rpd_checker.sv
module rpd_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              irq,
  input logic              dma_en,
  input logic              rx_en,
  input logic              sw_mode,
  input logic              wait_rel,
  input logic              ev_write,
  input logic              ev_full,
  input logic              ev_eop,
  input logic [1:0]        flags,
  input logic [1:0]        imr
);

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (dma_en && rx_en && !wait_rel)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_write && !ev_full && !ev_eop) |=> (!mem_req || mem_addr == $past(mem_addr) + 1'b1)); // R2

  AST_FULL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |=> flags[0]); // R3

  AST_EOP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eop |=> flags[1]); // R4

  AST_HOLD_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eop |=> !mem_req); // R6

  AST_SINGLE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_full && !sw_mode) |=> !rx_en); // R8

  AST_EOP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eop && imr[1]) |=> irq); // R9

endmodule

bind rx_pingpong_dma rpd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .irq      (irq),
  .dma_en   (ctrl.dma_en),
  .rx_en    (ctrl.rx_en),
  .sw_mode  (ctrl.sw_mode),
  .wait_rel (wait_rel),
  .ev_write (ev_write),
  .ev_full  (ev_full),
  .ev_eop   (ev_eop),
  .flags    (flags),
  .imr      (imr)
);

// File: tb/tb_rx_pingpong_dma.sv
`timescale 1ns/1ps
module tb_rx_pingpong_dma;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        fifo_valid = 1'b0, fifo_last = 1'b0;
  logic [7:0]  fifo_data = '0;
  logic        fifo_ready;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;
  logic        mem_ack = 1'b1;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;

  logic [23:0] log_addr [0:63];
  logic [7:0]  log_data [0:63];
  int          n_log = 0;

  localparam logic [23:0] B0 = 24'h123456;
  localparam logic [23:0] B1 = 24'hABCD00;

  always #2.5 clk = ~clk;

  rx_pingpong_dma dut (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .fifo_valid, .fifo_data, .fifo_last, .fifo_ready,
    .mem_req, .mem_addr, .mem_data, .mem_ack, .irq
  );

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack && n_log < 64) begin
      log_addr[n_log] = mem_addr;
      log_data[n_log] = mem_data;
      n_log++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = 4'(a);
    @(negedge clk); d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input bit last, output bit took);
    took = 0;
    fifo_valid = 1'b1; fifo_data = d; fifo_last = last;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (fifo_ready) begin took = 1; break; end
    end
    @(posedge clk); #1;
    fifo_valid = 1'b0; fifo_last = 1'b0;
  endtask

  task automatic set_base(input int ra, input logic [23:0] b);
    wr(ra, b[7:0]); wr(ra + 1, b[15:8]); wr(ra + 2, b[23:16]);
  endtask

  task automatic check_count(input string req, input int exp);
    logic [7:0] lo, hi;
    rd(10, lo); rd(11, hi);
    check(req, {16'h0, hi, lo}, 32'(exp));
  endtask

  task automatic check_isr(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(12, v);
    check(req, 32'(v), 32'(exp));
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, v);  check("R10 ctrl after reset", 32'(v), 0);
    rd(12, v); check("R10 isr after reset", 32'(v), 0);
    rd(13, v); check("R9 imr after reset", 32'(v), 3);
    check("R9 irq after reset", 32'(irq), 0);
    check("R1 no request after reset", 32'(mem_req), 0);
  endtask

  task automatic t_gating();
    bit took;
    int s;
    set_base(2, B0);
    wr(8, 8'd8); wr(9, 8'd0);
    wr(0, 8'h01);
    push(8'hA0, 0, took); check("R1 dma enable alone", 32'(took), 0);
    wr(0, 8'h02);
    push(8'hA0, 0, took); check("R1 rx enable alone", 32'(took), 0);
    wr(0, 8'h03);
    s = n_log;
    push(8'hA0, 0, took); push(8'hA1, 0, took); push(8'hA2, 1, took);
    check("R2 bytes logged", 32'(n_log - s), 3);
    check("R2 first addr at base", 32'(log_addr[s]), 32'(B0));
    check("R2 addr step", 32'(log_addr[s+2]), 32'(B0 + 24'd2));
    check("R2 data passed", 32'(log_data[s+1]), 32'hA1);
    check("R9 irq on eop", 32'(irq), 1);
    check_count("R5 count three", 3);
    check_isr("R4 eop flag", 8'h02);
    check_isr("R9 clear on read", 8'h00);
    check("R9 irq after clear", 32'(irq), 0);
    push(8'hB0, 1, took); check("R6 held before release", 32'(took), 0);
    wr(1, 8'h01);
    s = n_log;
    push(8'hB0, 1, took); check("R6 accepted after release", 32'(took), 1);
    check("R8 single mode back to base0", 32'(log_addr[s]), 32'(B0));
    check_isr("R4 eop one byte", 8'h02);
    wr(1, 8'h01);
  endtask

  task automatic t_full_single();
    bit took;
    int s;
    logic [7:0] v;
    wr(8, 8'd2);
    s = n_log;
    push(8'hC0, 0, took); push(8'hC1, 0, took);
    check("R2 second byte", 32'(log_addr[s+1]), 32'(B0 + 24'd1));
    rd(0, v); check("R8 rx enable dropped", 32'(v), 32'h01);
    push(8'hC2, 1, took); check("R8 held until re-enable", 32'(took), 0);
    check_isr("R3 full flag", 8'h01);
    wr(0, 8'h03);
    push(8'hC2, 1, took);
    check("R8 refill at base0", 32'(log_addr[s+2]), 32'(B0));
    check_count("R5 count across buffers", 3);
    check_isr("R4 eop after fill", 8'h02);
    wr(1, 8'h01);
  endtask

  task automatic t_switch();
    bit took;
    int s;
    set_base(5, B1);
    wr(0, 8'h07);
    s = n_log;
    push(8'hD0, 0, took); push(8'hD1, 0, took); push(8'hD2, 0, took);
    push(8'hD3, 0, took); push(8'hD4, 1, took);
    check("R7 third byte at base1", 32'(log_addr[s+2]), 32'(B1));
    check("R7 fourth byte", 32'(log_addr[s+3]), 32'(B1 + 24'd1));
    check("R7 fifth byte back at base0", 32'(log_addr[s+4]), 32'(B0));
    check_count("R5 count five", 5);
    check_isr("R3 full and eop flags", 8'h03);
    wr(1, 8'h01);
    s = n_log;
    push(8'hE0, 0, took); push(8'hE1, 1, took);
    check("R7 after eop uses base1", 32'(log_addr[s]), 32'(B1));
    check_isr("R4 fill on last byte eop only", 8'h02);
    check_count("R5 count two", 2);
    wr(1, 8'h01);
    s = n_log;
    push(8'hF0, 1, took);
    check("R7 swap after coincident end", 32'(log_addr[s]), 32'(B0));
    check_isr("R4 single byte", 8'h02);
    wr(1, 8'h01);
  endtask

  task automatic t_mask();
    bit took;
    wr(13, 8'h01);
    push(8'h11, 1, took);
    check("R9 masked eop no irq", 32'(irq), 0);
    check_isr("R9 flag still set", 8'h02);
    wr(1, 8'h01);
    wr(13, 8'h03);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    rd(5, v); check("R10 base1 low", 32'(v), 32'h00);
    rd(6, v); check("R10 base1 mid", 32'(v), 32'hCD);
    rd(7, v); check("R10 base1 high", 32'(v), 32'hAB);
    rd(4, v); check("R10 base0 high", 32'(v), 32'h12);
    rd(8, v); check("R10 maxsz low", 32'(v), 32'h02);
    rd(0, v); check("R10 ctrl", 32'(v), 32'h07);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_gating();
    t_full_single();
    t_switch();
    t_mask();
    t_readback();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule